// File: doc/BRIEF.md
# Color-Filter Gain Steering Sequencer

This block decides, pixel by pixel, which of four 6-bit gain codes a downstream pixel amplifier should use. The choice follows the layout of the sensor's color filter array. A line strobe (HD) and a frame strobe (VD) keep it aligned to the array. Both strobes are registered on the pixel clock. Rising and falling edges are found from the registered copies, and a per-line pattern generator then produces a 2-bit gain index in one of seven steering modes.

A 3-bit mode field picks the pattern. Two-phase mosaic modes alternate between two index pairs on successive lines. Interlace and field-select modes pick the pair from the frame strobe. Three- and four-color modes cycle the index across the line. A direct mode takes the index straight from the strobe levels. An enable input replaces the selected code with the fixed code 63 when it is low. The four codes arrive packed on one bus. Slot n occupies bits [6n+5:6n].

Top module: `gain_steer_top`

## Requirements
- R1: HD and VD are registered on the rising clock edge, and edges are found between consecutive registered values. An HD rising edge applied before clock edge k changes the pattern state at edge k+1, so the new index is seen after edge k+1.
- R2: Mode 3'b000 (off) keeps the gain index at 0.
- R3: Mode 3'b001 (mosaic separate): each line starts at pixel phase 0, and the index alternates within the pair {0,1} or the pair {2,3}. An HD rising edge while a VD rising edge is pending selects {0,1}. Any other HD rising edge swaps the pair.
- R4: Mode 3'b010 (interlace) behaves like R3, except that a pending VD edge of either direction selects {0,1}.
- R5: Mode 3'b011 (three-color): the index cycles 0,1,2 on every pixel. An HD rising edge while a VD rising edge is pending returns it to 0. Other HD edges do not interrupt the cycle.
- R6: Mode 3'b100 (four-color) follows the rule of R5 with the cycle 0,1,2,3.
- R7: Mode 3'b101 (field select): a pending VD falling edge selects pair {0,1} and a pending VD rising edge selects {2,3} at the next HD rising edge. A line with no pending VD edge keeps the previous pair.
- R8: Mode 3'b110 (mosaic repeat): lines alternate between pair {0,1} and pair {1,2}. A pending VD rising edge selects {0,1} at the next HD rising edge.
- R9: Mode 3'b111 (direct): the index is {registered VD, registered HD}.
- R10: With the enable low, the gain code output is 63 whatever the index.
- R11: With the enable high, the gain code output equals slot `gain_idx` of the gain bus, bits [6*idx+5 : 6*idx].
- R12: Only the most recent VD edge is pending. It is cleared by an HD rising edge. A VD edge found in the same cycle as an HD rising edge stays pending for the following line.
- R13: Synchronous reset clears the pattern state, the pending edge and the strobe history, so the index is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_in | input | 1 | Line sync strobe |
| vd_in | input | 1 | Frame sync strobe |
| steer_en | input | 1 | Gain steering enable; low forces code 63 |
| steer_mode | input | 3 | Steering mode select |
| gain_bank | input | 24 | Four packed gain codes, slot n at bits [6n+5:6n] |
| gain_idx | output | 2 | Selected gain slot |
| gain_code | output | 6 | Gain code applied to the current pixel |

## Verification
A wrong internal state shows up at the index port quickly. A pixel phase that is off by one flips the index on the very next pixel. A wrong line pair shows on the first pixel after the HD edge is taken, two clock edges after HD rises. A pending VD flag that is wrong stays hidden until the next HD rising edge, where it picks the wrong pair or skips a restart for the whole line. The bench therefore compares index and code against a reference on every cycle, across lines that carry VD rises, falls, short VD pulses and VD edges coinciding with HD.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int NUM_GAINS = 4;
    localparam int IDX_W     = $clog2(NUM_GAINS);

    typedef enum logic [2:0] {
        MODE_OFF        = 3'd0,
        MODE_MOSAIC_SEP = 3'd1,
        MODE_INTERLACE  = 3'd2,
        MODE_TRI        = 3'd3,
        MODE_QUAD       = 3'd4,
        MODE_FIELD      = 3'd5,
        MODE_MOSAIC_REP = 3'd6,
        MODE_DIRECT     = 3'd7
    } steer_mode_e;

    // Strobe events derived from the registered HD/VD copies
    typedef struct packed {
        logic hd_lvl;
        logic vd_lvl;
        logic hd_rise;
        logic vd_rise;
        logic vd_fall;
    } sync_ev_t;

    // Pattern generator state
    typedef struct packed {
        logic [IDX_W-1:0] pix;       // position within the in-line pattern
        logic             phase;     // line pair: 0 = first pair, 1 = second
        logic             pend_rise; // VD rose since last HD rising edge
        logic             pend_fall; // VD fell since last HD rising edge
    } seq_state_t;

    function automatic logic [IDX_W-1:0] pix_last(steer_mode_e m);
        case (m)
            MODE_TRI:  return IDX_W'(2);
            MODE_QUAD: return IDX_W'(3);
            default:   return IDX_W'(1);
        endcase
    endfunction

    function automatic logic is_two_phase(steer_mode_e m);
        return (m == MODE_MOSAIC_SEP) || (m == MODE_INTERLACE) ||
               (m == MODE_FIELD)      || (m == MODE_MOSAIC_REP);
    endfunction

    function automatic logic [IDX_W-1:0] map_index(steer_mode_e m,
                                                   seq_state_t  st,
                                                   logic        hd,
                                                   logic        vd);
        case (m)
            MODE_MOSAIC_SEP,
            MODE_INTERLACE,
            MODE_FIELD:      return {st.phase, st.pix[0]};
            MODE_MOSAIC_REP: return st.phase ? (st.pix[0] ? IDX_W'(2) : IDX_W'(1))
                                             : IDX_W'(st.pix[0]);
            MODE_TRI,
            MODE_QUAD:       return st.pix;
            MODE_DIRECT:     return {vd, hd};
            default:         return '0;
        endcase
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] cur_q;
    logic [N-1:0] old_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q[i] <= 1'b0;
                old_q[i] <= 1'b0;
            end else begin
                cur_q[i] <= din[i];
                old_q[i] <= cur_q[i];
            end
        end
        assign lvl[i]  = cur_q[i];
        assign rise[i] = cur_q[i] & ~old_q[i];
        assign fall[i] = ~cur_q[i] & old_q[i];
    end

    // R1: the registered copy follows the input one edge later
    a_r1_sample_delay: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> lvl == $past(din));
    // R1: a signal cannot rise and fall in the same cycle
    a_r1_edge_excl: assert property (@(posedge clk) disable iff (rst)
        (rise & fall) == '0);

endmodule

// File: rtl/steer_seq.sv
module steer_seq
    import steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  steer_mode_e      mode,
    input  sync_ev_t         ev,
    output logic [IDX_W-1:0] idx
);
    seq_state_t st_q;
    seq_state_t st_d;
    logic [IDX_W-1:0] pix_step;

    assign pix_step = (st_q.pix >= pix_last(mode)) ? '0 : st_q.pix + 1'b1;

    always_comb begin
        st_d     = st_q;
        st_d.pix = pix_step;
        if (ev.hd_rise) begin
            if (is_two_phase(mode)) st_d.pix = '0;
            case (mode)
                MODE_MOSAIC_SEP,
                MODE_MOSAIC_REP: st_d.phase = st_q.pend_rise ? 1'b0 : ~st_q.phase;
                MODE_INTERLACE:  st_d.phase = (st_q.pend_rise | st_q.pend_fall) ? 1'b0
                                                                                : ~st_q.phase;
                MODE_FIELD: begin
                    if (st_q.pend_fall)      st_d.phase = 1'b0;
                    else if (st_q.pend_rise) st_d.phase = 1'b1;
                end
                MODE_TRI,
                MODE_QUAD: if (st_q.pend_rise) st_d.pix = '0;
                default: ;
            endcase
            st_d.pend_rise = 1'b0;
            st_d.pend_fall = 1'b0;
        end
        if (ev.vd_rise) begin
            st_d.pend_rise = 1'b1;
            st_d.pend_fall = 1'b0;
        end
        if (ev.vd_fall) begin
            st_d.pend_fall = 1'b1;
            st_d.pend_rise = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign idx = map_index(mode, st_q, ev.hd_lvl, ev.vd_lvl);

    // R12: at most one VD edge is pending
    a_r12_one_pending: assert property (@(posedge clk) disable iff (rst)
        !(st_q.pend_rise && st_q.pend_fall));
    // R12: an HD rising edge without a VD edge leaves nothing pending
    a_r12_hd_clears: assert property (@(posedge clk) disable iff (rst)
        (ev.hd_rise && !ev.vd_rise && !ev.vd_fall) |=> !st_q.pend_rise && !st_q.pend_fall);
    // R3 / R8: restart on the first pair after a pending VD rise
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        (ev.hd_rise && st_q.pend_rise &&
         (mode == MODE_MOSAIC_SEP || mode == MODE_MOSAIC_REP) && $stable(mode))
        |=> idx == '0);
    // R5: three-color index never reaches 3 once the mode has settled
    a_r5_tri_range: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRI && $past(mode) == MODE_TRI && $past(!rst)) |-> idx != 2'd3);
    // R7: a line with no pending VD edge keeps the pair in field select
    a_r7_hold_pair: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FIELD && ev.hd_rise && !st_q.pend_rise && !st_q.pend_fall)
        |=> $stable(st_q.phase));

endmodule

// File: rtl/gain_pick.sv
module gain_pick
    import steer_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic                        en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NUM_GAINS*GAIN_W-1:0] bank,
    output logic [GAIN_W-1:0]           code
);
    logic [GAIN_W-1:0] slot [NUM_GAINS];

    for (genvar g = 0; g < NUM_GAINS; g++) begin : g_slot
        assign slot[g] = bank[g*GAIN_W +: GAIN_W];
    end

    assign code = en ? slot[idx] : '1;

endmodule

// File: rtl/gain_steer_top.sv
module gain_steer_top
    import steer_pkg::*;
#(
    parameter int GAIN_W = 6,
    localparam int BANK_W = NUM_GAINS * GAIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hd_in,
    input  logic              vd_in,
    input  logic              steer_en,
    input  logic [2:0]        steer_mode,
    input  logic [BANK_W-1:0] gain_bank,
    output logic [IDX_W-1:0]  gain_idx,
    output logic [GAIN_W-1:0] gain_code
);
    logic [1:0]  s_lvl;
    logic [1:0]  s_rise;
    logic [1:0]  s_fall;
    sync_ev_t    ev;
    steer_mode_e mode;

    assign mode = steer_mode_e'(steer_mode);

    strobe_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  ({vd_in, hd_in}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    always_comb begin
        ev.hd_lvl  = s_lvl[0];
        ev.vd_lvl  = s_lvl[1];
        ev.hd_rise = s_rise[0];
        ev.vd_rise = s_rise[1];
        ev.vd_fall = s_fall[1];
    end

    steer_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .ev   (ev),
        .idx  (gain_idx)
    );

    gain_pick #(.GAIN_W(GAIN_W)) u_pick (
        .en   (steer_en),
        .idx  (gain_idx),
        .bank (gain_bank),
        .code (gain_code)
    );

    // R2: off mode keeps slot 0
    a_r2_off_slot0: assert property (@(posedge clk) disable iff (rst)
        (steer_mode == 3'd0) |-> gain_idx == '0);
    // R11: enabled code matches the indexed slot
    a_r11_slot_code: assert property (@(posedge clk) disable iff (rst)
        steer_en |-> gain_code == gain_bank[gain_idx*GAIN_W +: GAIN_W]);
    // R10: disabled code is the fixed maximum
    a_r10_fixed_code: assert property (@(posedge clk) disable iff (rst)
        !steer_en |-> gain_code == {GAIN_W{1'b1}});
    // R13: reset leaves the index at slot 0 outside direct mode
    a_r13_reset_idx: assert property (@(posedge clk)
        ($past(rst) && steer_mode != 3'd7) |-> gain_idx == '0);

endmodule

// File: tb/tb_gain_steer_top.sv
module tb_gain_steer_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hd = 1'b0;
    logic        vd = 1'b0;
    logic        en = 1'b1;
    logic [2:0]  mode = 3'd0;
    logic [23:0] bank = '0;
    logic [1:0]  idx;
    logic [5:0]  code;

    int checks = 0;
    int fails = 0;
    bit started = 0;
    string cur_tag = "";

    // reference model state
    bit m_hs, m_hp, m_vs, m_vp;
    int m_pix;
    bit m_phase, m_pr, m_pf;
    bit r_hr, r_vr, r_vf, r_nph, r_npr, r_npf;
    int r_last, r_np;

    always #4 clk = ~clk;

    gain_steer_top dut (
        .clk        (clk),
        .rst        (rst),
        .hd_in      (hd),
        .vd_in      (vd),
        .steer_en   (en),
        .steer_mode (mode),
        .gain_bank  (bank),
        .gain_idx   (idx),
        .gain_code  (code)
    );

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_hs = 0; m_hp = 0; m_vs = 0; m_vp = 0;
            m_pix = 0; m_phase = 0; m_pr = 0; m_pf = 0;
        end else begin
            r_hr = m_hs && !m_hp;
            r_vr = m_vs && !m_vp;
            r_vf = !m_vs && m_vp;
            r_last = (mode == 3'd3) ? 2 : (mode == 3'd4) ? 3 : 1;
            r_np = (m_pix >= r_last) ? 0 : m_pix + 1;
            r_nph = m_phase; r_npr = m_pr; r_npf = m_pf;
            if (r_hr) begin
                if (mode == 3'd1 || mode == 3'd6) begin
                    r_np = 0; r_nph = m_pr ? 1'b0 : !m_phase;
                end else if (mode == 3'd2) begin
                    r_np = 0; r_nph = (m_pr || m_pf) ? 1'b0 : !m_phase;
                end else if (mode == 3'd5) begin
                    r_np = 0;
                    if (m_pf) r_nph = 0;
                    else if (m_pr) r_nph = 1;
                end else if ((mode == 3'd3 || mode == 3'd4) && m_pr) begin
                    r_np = 0;
                end
                r_npr = 0; r_npf = 0;
            end
            if (r_vr) begin r_npr = 1; r_npf = 0; end
            if (r_vf) begin r_npf = 1; r_npr = 0; end
            m_pix = r_np; m_phase = r_nph; m_pr = r_npr; m_pf = r_npf;
            m_hp = m_hs; m_hs = hd;
            m_vp = m_vs; m_vs = vd;
        end
    end

    function automatic int exp_idx();
        case (mode)
            3'd1, 3'd2, 3'd5: return (m_phase ? 2 : 0) + (m_pix % 2);
            3'd6:             return m_phase ? 1 + (m_pix % 2) : (m_pix % 2);
            3'd3, 3'd4:       return m_pix;
            3'd7:             return (m_vs ? 2 : 0) + (m_hs ? 1 : 0);
            default:          return 0;
        endcase
    endfunction

    function automatic string mode_tag();
        case (mode)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(negedge clk) begin
        if (started) begin
            int ei;
            int ec;
            string t;
            ei = exp_idx();
            ec = en ? int'(bank[ei*6 +: 6]) : 63;
            t = rst ? "R13" : (cur_tag != "" ? cur_tag : mode_tag());
            checks++;
            if (int'(idx) != ei) begin
                fails++;
                $display("FAIL %s idx actual=%0d expected=%0d t=%0t", t, idx, ei, $time);
            end
            checks++;
            if (int'(code) != ec) begin
                fails++;
                $display("FAIL %s code actual=%0d expected=%0d t=%0t",
                         en ? "R11" : "R10", code, ec, $time);
            end
        end
    end

    task automatic drive(input bit h, input bit v);
        @(posedge clk);
        #2;
        hd = h;
        vd = v;
    endtask

    // Ten lines of varying length with VD rises, falls, a short pulse
    // and a VD rise coincident with HD.
    task automatic run_mode(input int m, input bit e, input logic [23:0] b);
        bit v;
        rst = 1'b1; mode = 3'(m); en = e; bank = b; hd = 0; vd = 0;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        v = 0;
        for (int ln = 0; ln < 10; ln++) begin
            int len;
            len = 7 + (ln % 3);
            for (int p = 0; p < len; p++) begin
                if (ln == 1 && p == 3) v = 1;
                if (ln == 4 && p == 4) v = 0;
                if (ln == 6 && p == 3) v = 1;
                if (ln == 6 && p == 5) v = 0;   // R12: latest edge wins
                if (ln == 8 && p == 0) v = 1;   // R12: coincident with HD
                if (ln == 9 && p == 4) v = 0;
                cur_tag = (ln >= 6 && ln <= 9 && p < 3 && m != 0 && m != 7) ? "R12" : "";
                drive(p < 2, v);
            end
        end
        cur_tag = "";
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R13 reset state is compared while rst is held
        repeat (3) @(posedge clk);
        for (int m = 0; m < 8; m++) begin
            run_mode(m, 1'b1, {6'd45, 6'd30, 6'd17, 6'd5});
        end
        // R10: disabled output across a steering mode
        run_mode(1, 1'b0, {6'd1, 6'd2, 6'd3, 6'd4});
        // R11: a different bank content
        run_mode(4, 1'b1, {6'd63, 6'd0, 6'd42, 6'd21});
        // R1: latency of an HD edge in mosaic separate mode
        cur_tag = "R1";
        rst = 1'b1; mode = 3'd1; en = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        drive(0, 0); drive(0, 0); drive(1, 0); drive(0, 0);
        drive(0, 0); drive(0, 0); drive(1, 0); drive(1, 0);
        drive(0, 0); drive(0, 0);
        @(posedge clk);
        cur_tag = "";
        @(negedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule